// File: doc/BRIEF.md
# Rectangular Frame-Memory Transfer Engine

This block moves a rectangle of 16-bit pixels between a 32-bit word stream and a frame memory of 1024 columns by 512 rows. A one-cycle start pulse carries a position word, a size word and a direction bit. In write direction each accepted input word becomes two pixel writes. In read direction pairs of pixel reads are packed into output words. Pixels are visited row by row, left to right. The source may stall or pause at any word. The engine keeps its row and column cursor across such gaps, so a transfer can arrive in several bursts that need not end on a row boundary.

The frame memory is reached through one synchronous port with a one-cycle read latency. The input stream (`in_*`) and the output stream (`out_*`) both use valid/ready. A word moves only in a cycle where valid and ready are both high at the rising edge. The engine never drops `out_valid` or changes `out_data` until the word is taken. The source may raise or drop `in_valid` freely, and an unaccepted word may be replaced. Control and status pins are plain levels or pulses.

Top module: `vrect_xfer_engine`

## Requirements
- R1: The start column is taken from position bits 9:0 and the start row from position bits 24:16. All other position bits are ignored.
- R2: Width is size bits 9:0, and a value of 0 there means 1024 columns. Other size bits do not affect the width.
- R3: Height is size bits 24:16, and a value of 0 there means 512 rows.
- R4: In write direction, bits 15:0 of an accepted word are written before bits 31:16, and pixels are visited row-major. If the pixel count is odd, the unused upper half of the final word is not written. `in_ready` is low whenever no further word belongs to the transfer.
- R5: A pixel at row r and column c is at memory address r*1024+c. The column wraps modulo 1024 and the row wraps modulo 512.
- R6: Pauses and stalls on either stream do not lose or repeat a pixel, including pauses in the middle of a row.
- R7: In read direction, the first pixel of each pair goes to bits 15:0 and the second to bits 31:16. If the pixel count is odd, the final word has bits 31:16 equal to 0. A presented word holds until accepted.
- R8: At the start of a read the first word is fetched ahead of demand. `out_valid` rises on the third rising edge after the edge that takes `start`, without any `out_ready`.
- R9: `busy` is high from the edge that takes `start` until the last pixel has been accessed. `rd_active` is high during the same interval for read transfers only.
- R10: `done` is a one-cycle pulse, raised on the edge after the last pixel's memory access.
- R11: A `start` while `busy` discards the old transfer, begins the new one, and raises `err` for exactly one cycle.
- R12: After reset, `busy`, `rd_active`, `done`, `err`, `out_valid` and `in_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| start_pos | input | 32 | Position word: column 9:0, row 24:16 |
| start_size | input | 32 | Size word: width 9:0, height 24:16 |
| start_rd | input | 1 | 1 = memory to stream, 0 = stream to memory |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word accepted at this edge if offered |
| in_data | input | 32 | Two pixels, first in bits 15:0 |
| out_valid | output | 1 | Output word presented |
| out_ready | input | 1 | Sink takes the presented word |
| out_data | output | 32 | Two pixels, first in bits 15:0 |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 19 | Pixel address row*1024+column |
| mem_wdata | output | 16 | Pixel to write |
| mem_rdata | input | 16 | Read pixel, valid one cycle after the access |
| busy | output | 1 | Transfer in progress |
| rd_active | output | 1 | Read transfer in progress (image-ready flag) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle restart-while-busy flag |

## Verification
Some results are due at a fixed distance from a stimulus. A memory write appears in the same cycle the word's pixel is in turn. `done` follows the last access by one edge. `err` follows the offending start by one edge. The first read word becomes valid three edges after the start is taken. The bench drives every input at the falling edge and samples outputs at the falling edge. The prefetch check counts exactly three falling edges after the start and also confirms that the word is not yet valid one edge earlier. For stream results with no fixed latency, the bench waits on the handshake and then compares values. Pulse counts and memory contents are compared only after a settling window of several cycles past the final handshake.

// File: rtl/vrx_pkg.sv
package vrx_pkg;
  localparam int X_W     = 10;           // column index bits
  localparam int Y_W     = 9;            // row index bits
  localparam int PIX_W   = 16;
  localparam int WORD_W  = 2 * PIX_W;
  localparam int ADDR_W  = X_W + Y_W;
  localparam int HI_LSB  = 16;           // lsb of the row/height field

  typedef struct packed {
    logic [X_W-1:0] x;
    logic [Y_W-1:0] y;
    logic [X_W:0]   w;   // 1 .. 2**X_W
    logic [Y_W:0]   h;   // 1 .. 2**Y_W
    logic           rd;
  } xfer_cfg_t;
endpackage

// File: rtl/vrx_decode.sv
module vrx_decode
  import vrx_pkg::*;
(
  input  logic [31:0] pos,
  input  logic [31:0] size,
  input  logic        rd,
  output xfer_cfg_t   cfg
);
  logic [X_W-1:0] wf;
  logic [Y_W-1:0] hf;
  logic           unused_bits;

  assign wf = size[X_W-1:0];
  assign hf = size[HI_LSB +: Y_W];

  always_comb begin
    cfg.x  = pos[X_W-1:0];
    cfg.y  = pos[HI_LSB +: Y_W];
    cfg.w  = (wf == '0) ? {1'b1, {X_W{1'b0}}} : {1'b0, wf};
    cfg.h  = (hf == '0) ? {1'b1, {Y_W{1'b0}}} : {1'b0, hf};
    cfg.rd = rd;
  end

  assign unused_bits = ^{pos[31:HI_LSB+Y_W], pos[HI_LSB-1:X_W],
                         size[31:HI_LSB+Y_W], size[HI_LSB-1:X_W]};
endmodule

// File: rtl/vrx_cursor.sv
module vrx_cursor
  import vrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  xfer_cfg_t         cfg,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic              rd,
  output logic              last
);
  logic [X_W-1:0] x0;
  logic [Y_W-1:0] row;
  logic [X_W:0]   off;
  logic [X_W:0]   wid;
  logic [Y_W:0]   rows_left;
  logic [X_W-1:0] col;
  logic           row_end;

  assign col     = x0 + off[X_W-1:0];
  assign addr    = {row, col};
  assign row_end = (off == wid - 1'b1);
  assign last    = active && row_end && (rows_left == 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      rd        <= 1'b0;
      x0        <= '0;
      row       <= '0;
      off       <= '0;
      wid       <= '0;
      rows_left <= '0;
    end else if (load) begin
      active    <= 1'b1;
      rd        <= cfg.rd;
      x0        <= cfg.x;
      row       <= cfg.y;
      off       <= '0;
      wid       <= cfg.w;
      rows_left <= cfg.h;
    end else if (step && active) begin
      if (row_end) begin
        off       <= '0;
        row       <= row + 1'b1;
        rows_left <= rows_left - 1'b1;
        if (rows_left == 1) active <= 1'b0;
      end else begin
        off <= off + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vrx_unpack.sv
module vrx_unpack
  import vrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              last,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              px_valid,
  output logic [PIX_W-1:0]  px_data
);
  logic [1:0]        cnt;
  logic [WORD_W-1:0] hold;
  logic              take;

  assign px_valid = en && (cnt != 2'd0);
  assign px_data  = (cnt == 2'd2) ? hold[PIX_W-1:0] : hold[WORD_W-1:PIX_W];
  assign in_ready = en && ((cnt == 2'd0) || (cnt == 2'd1 && !last));
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt  <= 2'd0;
      hold <= '0;
    end else if (take) begin
      hold <= in_data;
      cnt  <= 2'd2;
    end else if (px_valid) begin
      cnt <= last ? 2'd0 : cnt - 2'd1;
    end
  end
endmodule

// File: rtl/vrx_pack.sv
module vrx_pack
  import vrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              last,
  input  logic [PIX_W-1:0]  rdata,
  output logic              issue,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  logic [1:0] nsent;    // 0 idle, 1 low issued, 2 word complete in flight
  logic       cap_lo, cap_hi, fin;
  logic       issue_lo, issue_hi;

  assign issue_lo = en && !out_valid && (nsent == 2'd0);
  assign issue_hi = en && (nsent == 2'd1);
  assign issue    = issue_lo || issue_hi;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      nsent     <= 2'd0;
      cap_lo    <= 1'b0;
      cap_hi    <= 1'b0;
      fin       <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      cap_lo <= issue_lo;
      cap_hi <= issue_hi;
      fin    <= (issue_lo && last) || issue_hi;
      if (issue_lo)      nsent <= last ? 2'd2 : 2'd1;
      else if (issue_hi) nsent <= 2'd2;
      else if (fin)      nsent <= 2'd0;
      if (cap_lo) out_data <= {{PIX_W{1'b0}}, rdata};
      if (cap_hi) out_data[WORD_W-1:PIX_W] <= rdata;
      if (fin)                         out_valid <= 1'b1;
      else if (out_valid && out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vrect_xfer_engine.sv
module vrect_xfer_engine
  import vrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       start_pos,
  input  logic [31:0]       start_size,
  input  logic              start_rd,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata,
  output logic              busy,
  output logic              rd_active,
  output logic              done,
  output logic              err
);
  xfer_cfg_t cfg;
  logic      act, rd, last, px_valid, issue, step;

  vrx_decode u_dec (.pos(start_pos), .size(start_size), .rd(start_rd), .cfg(cfg));

  vrx_cursor u_cur (
    .clk(clk), .rst_n(rst_n), .load(start), .cfg(cfg), .step(step),
    .addr(mem_addr), .active(act), .rd(rd), .last(last));

  vrx_unpack u_unp (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(act && !rd), .last(last),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .px_valid(px_valid), .px_data(mem_wdata));

  vrx_pack u_pck (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(act && rd), .last(last),
    .rdata(mem_rdata), .issue(issue), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  assign step      = px_valid || issue;
  assign mem_en    = step;
  assign mem_we    = px_valid;
  assign busy      = act;
  assign rd_active = act && rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= step && last && !start;
      err  <= start && act;
    end
  end
endmodule

// File: rtl/vrx_xfer_chk.sv
module vrx_xfer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        mem_en,
  input logic        mem_we,
  input logic        busy,
  input logic        rd_active,
  input logic        done,
  input logic        err
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> $past(start));
  // R9
  rd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_active |-> busy);
  // R4
  in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready |-> (busy && !rd_active));
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));
  // R4
  we_en_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_en);
endmodule

bind vrect_xfer_engine vrx_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .mem_en(mem_en), .mem_we(mem_we), .busy(busy), .rd_active(rd_active),
  .done(done), .err(err));

// File: tb/sim_vrect_xfer_engine.sv
`timescale 1ns/1ps
module sim_vrect_xfer_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, start_rd = 1'b0;
  logic [31:0] start_pos = '0, start_size = '0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_data;
  logic        mem_en, mem_we;
  logic [18:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0;
  logic        busy, rd_active, done, err;

  int ncmp = 0, nbad = 0, ndone = 0, nerr = 0, nwr = 0;
  bit finished = 0;
  logic [15:0] wr [int];

  always #4 clk = ~clk;

  vrect_xfer_engine u0 (.*);

  function automatic logic [15:0] pat(input int a);
    logic [18:0] v = 19'(a);
    return v[15:0] ^ {v[18:16], 13'h0} ^ 16'h5A3C;
  endfunction

  always @(posedge clk) begin
    if (mem_en && mem_we) begin wr[int'(mem_addr)] = mem_wdata; nwr++; end
    if (mem_en && !mem_we) mem_rdata <= pat(int'(mem_addr));
    if (done) ndone++;
    if (err) nerr++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int eaddr(input int x, input int y, input int w, input int k);
    return (((y + k / w) % 512) * 1024) + ((x + k % w) % 1024);
  endfunction

  task automatic kick(input logic [31:0] p, input logic [31:0] s, input logic r);
    start_pos = p; start_size = s; start_rd = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    in_data = d; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop(output logic [31:0] d);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    d = out_data;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  function automatic logic [15:0] wval(input int k);
    return 16'(16'h1000 + k * 7);
  endfunction

  task automatic run_xfer(input logic [31:0] p, input logic [31:0] s, input logic r,
                          input bit gap, input string req);
    int x = int'(p & 32'h3FF);
    int y = int'((p >> 16) & 32'h1FF);
    int w = int'(((s - 1) & 32'h3FF) + 1);
    int h = int'((((s >> 16) - 1) & 32'h1FF) + 1);
    int npx = w * h;
    int nw = (npx + 1) / 2;
    logic [31:0] d, e;
    wr.delete(); nwr = 0; ndone = 0;
    kick(p, s, r);
    if (!r) begin
      for (int j = 0; j < nw; j++) begin
        if (gap && j % 3 == 2) repeat (3) @(negedge clk);
        push({wval(2 * j + 1), wval(2 * j)});
      end
      repeat (5) @(negedge clk);
      for (int k = 0; k < npx; k++) begin
        int a = eaddr(x, y, w, k);
        chk(wr.exists(a) && wr[a] == wval(k), {req, " R4 R5 pixel write"},
            wr.exists(a) ? 32'(wr[a]) : 32'hDEAD, 32'(wval(k)));
      end
      chk(nwr == npx, {req, " R4 write count"}, nwr, npx);
      chk(in_ready == 1'b0, {req, " R4 in_ready after end"}, in_ready, 0);
    end else begin
      for (int j = 0; j < nw; j++) begin
        if (gap && j % 2 == 1) repeat (2) @(negedge clk);
        pop(d);
        e[15:0]  = pat(eaddr(x, y, w, 2 * j));
        e[31:16] = (2 * j + 1 < npx) ? pat(eaddr(x, y, w, 2 * j + 1)) : 16'h0;
        chk(d == e, {req, " R7 R5 read word"}, d, e);
      end
      repeat (5) @(negedge clk);
      chk(out_valid == 1'b0, {req, " R7 no extra word"}, out_valid, 0);
      chk(rd_active == 1'b0, {req, " R9 read flag cleared"}, rd_active, 0);
    end
    chk(ndone == 1, {req, " R10 one done pulse"}, ndone, 1);
    chk(busy == 1'b0, {req, " R9 idle"}, busy, 0);
  endtask

  localparam int NV = 4;
  localparam logic [31:0] V_POS  [NV] = '{32'h0003_0005, 32'h81FF_FFFE, 32'h0014_000A, 32'h01FE_03FC};
  localparam logic [31:0] V_SIZE [NV] = '{32'h0002_0004, 32'hF002_0003, 32'h0003_0003, 32'h0003_0006};
  localparam logic        V_RD   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1};
  localparam bit          V_GAP  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nbad++; ncmp++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk({busy, rd_active, done, err, out_valid, in_ready} == 6'b0, "R12 reset outputs",
        {busy, rd_active, done, err, out_valid, in_ready}, 0);

    // Vector table: R1 field positions, R4/R5 write, R6 gaps, R7 read
    for (int i = 0; i < NV; i++)
      run_xfer(V_POS[i], V_SIZE[i], V_RD[i], V_GAP[i], $sformatf("R1 R6 vec%0d", i));

    // R2 width field 0 -> 1024 columns
    run_xfer(32'h0007_0000, 32'h0001_0000, 1'b0, 1'b0, "R2 full width");
    // R3 height field 0 -> 512 rows
    run_xfer(32'h0000_0200, 32'h0000_0001, 1'b1, 1'b0, "R3 full height");

    // R8 prefetch and R9 read flag
    ndone = 0;
    kick(32'h0005_0009, 32'h0001_0002, 1'b1);
    chk(rd_active && busy, "R9 read flag set", {rd_active, busy}, 2'b11);
    @(negedge clk); @(negedge clk);
    chk(out_valid == 1'b0, "R8 not yet valid", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R8 prefetched valid", out_valid, 1);
    chk(out_data == {pat(5 * 1024 + 10), pat(5 * 1024 + 9)}, "R8 prefetched data",
        out_data, {pat(5 * 1024 + 10), pat(5 * 1024 + 9)});
    pop(d);
    repeat (3) @(negedge clk);
    chk(rd_active == 1'b0 && ndone == 1, "R9 R10 read end", {rd_active, 8'(ndone)}, 1);

    // R11 restart while busy
    wr.delete(); nwr = 0; ndone = 0; nerr = 0;
    kick(32'h0, 32'h0002_0004, 1'b0);
    push(32'hBBBB_AAAA);
    repeat (3) @(negedge clk);
    kick(32'h0000_0040, 32'h0001_0002, 1'b1);
    pop(d);
    chk(d == {pat(65), pat(64)}, "R11 new transfer data", d, {pat(65), pat(64)});
    repeat (4) @(negedge clk);
    chk(nerr == 1, "R11 err one cycle", nerr, 1);
    chk(nwr == 2, "R11 old transfer discarded", nwr, 2);
    chk(ndone == 1, "R11 R10 single done", ndone, 1);
    chk(in_ready == 1'b0 && busy == 1'b0, "R11 idle after", {in_ready, busy}, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule